// File: doc/BRIEF.md
# Scaling step and phase calculator

This block turns a pair of picture resolutions into the per-axis step values that a polyphase scaler walks with, and the start phases for the chroma planes. All values are fixed-point with 13 fractional bits. A one-cycle `start` pulse captures the source and destination width and height, the source and destination sampling formats and a chroma siting code. The block then works out the four increments in turn: luma vertical, chroma vertical, luma horizontal and chroma horizontal. It raises `done` for one cycle when all four are ready.

Each increment is a round-to-nearest quotient of the source size over the destination size. One restoring divider, shared by all four, produces one quotient bit per cycle. The chroma sizes come from the luma sizes according to the subsampling of each format. The chroma start phases are negative offsets that move the sampled chroma onto the first luma line or column. They are non-zero only for a 4:2:0 source.

Top module: `scale_step_calc`

## Requirements
- R1: A `start` pulse while idle captures all inputs. After the fourth quotient, `done` is high for exactly one cycle, and the outputs then hold until the next accepted start.
- R2: The luma vertical increment is ((src_h << 13) + (dst_h >> 1)) / dst_h and the luma horizontal increment is ((src_w << 13) + (dst_w >> 1)) / dst_w. Each increment output keeps the low 16 bits of its quotient. Equal non-zero sizes give 8192.
- R3: Format code 0 (4:2:0) halves both the chroma source width and the chroma source height. Code 1 (4:2:2) halves only the chroma source width. Code 2 (4:4:4 or RGB) halves neither. The chroma increments use the same rounding formula as R2.
- R4: A destination format code of 1 (4:2:2) halves the chroma destination width before the chroma horizontal increment is formed. The chroma destination height always equals dst_h.
- R5: Any divisor that is zero, after halving, is replaced by one. This applies to the divisor and to the rounding half alike.
- R6: With a 4:2:0 source, the chroma vertical phase depends on the siting code. Codes 0 and 1 give -2048, codes 4 and 5 give -4096, and all other codes give 0. The value is a 16-bit two's-complement field.
- R7: With a 4:2:0 source, siting codes 1, 3 and 5 give a chroma horizontal phase of -2048, and all other codes give 0. The value is a 19-bit two's-complement field.
- R8: With any source format other than 4:2:0, both chroma phases are 0 whatever the siting code.
- R9: A `start` pulse that arrives during a computation is ignored, and the outputs that follow reflect the inputs captured first.
- R10: After reset all increments and phases are 0 and `done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch pulse, accepted while idle |
| src_w | input | 12 | Source width in pixels |
| src_h | input | 12 | Source height in lines |
| dst_w | input | 12 | Destination width in pixels |
| dst_h | input | 12 | Destination height in lines |
| src_fmt | input | 2 | Source format: 0 = 4:2:0, 1 = 4:2:2, 2 = 4:4:4 |
| dst_fmt | input | 2 | Destination format, same coding |
| siting | input | 3 | Chroma siting code 0..5 |
| done | output | 1 | One-cycle pulse when results are valid |
| luma_v_inc | output | 16 | Luma vertical increment |
| luma_h_inc | output | 16 | Luma horizontal increment |
| chroma_v_inc | output | 16 | Chroma vertical increment |
| chroma_h_inc | output | 16 | Chroma horizontal increment |
| chroma_v_phase | output | 16 | Chroma vertical start phase |
| chroma_h_phase | output | 19 | Chroma horizontal start phase |

## Verification
The assertions assume that `start` is the only control input and that inputs matter only in the cycle `start` is accepted. Those inputs are then held in capture registers, so later input changes cannot disturb the properties. The unity-step property also assumes that source and destination widths are captured together and are non-zero. The stimulus drives format codes 0 to 2 and siting codes 0 to 7, including the unused codes 6 and 7. It includes zero destination sizes and sizes of one and 4095. It also fires a stray start in the middle of a computation, and each of these cases stays inside the assumptions above.

// File: rtl/scl_pkg.sv
package scl_pkg;
  localparam logic [1:0] FMT_420 = 2'd0;
  localparam logic [1:0] FMT_422 = 2'd1;
  localparam logic [1:0] FMT_444 = 2'd2;

  typedef enum logic [1:0] {
    OP_LUMA_V   = 2'd0,
    OP_CHROMA_V = 2'd1,
    OP_LUMA_H   = 2'd2,
    OP_CHROMA_H = 2'd3
  } div_op_e;
endpackage

// File: rtl/scl_prep.sv
module scl_prep
  import scl_pkg::*;
#(
  parameter int DIM_W = 12,
  parameter int FRAC  = 13,
  parameter int VPH_W = 16,
  parameter int HPH_W = 19
) (
  input  logic [DIM_W-1:0] src_w,
  input  logic [DIM_W-1:0] src_h,
  input  logic [DIM_W-1:0] dst_w,
  input  logic [1:0]       src_fmt,
  input  logic [1:0]       dst_fmt,
  input  logic [2:0]       siting,
  output logic [DIM_W-1:0] c_src_w,
  output logic [DIM_W-1:0] c_src_h,
  output logic [DIM_W-1:0] c_dst_w,
  output logic [VPH_W-1:0] c_vph,
  output logic [HPH_W-1:0] c_hph
);
  localparam int QUARTER = 1 << (FRAC - 2);
  localparam int HALF    = 1 << (FRAC - 1);

  always_comb begin
    c_src_w = (src_fmt == FMT_420 || src_fmt == FMT_422) ? (src_w >> 1) : src_w;
    c_src_h = (src_fmt == FMT_420) ? (src_h >> 1) : src_h;
    c_dst_w = (dst_fmt == FMT_422) ? (dst_w >> 1) : dst_w;
    c_vph   = '0;
    c_hph   = '0;
    if (src_fmt == FMT_420) begin
      case (siting)
        3'd0, 3'd1: c_vph = VPH_W'(0) - VPH_W'(QUARTER);
        3'd4, 3'd5: c_vph = VPH_W'(0) - VPH_W'(HALF);
        default:    c_vph = '0;
      endcase
      case (siting)
        3'd1, 3'd3, 3'd5: c_hph = HPH_W'(0) - HPH_W'(QUARTER);
        default:          c_hph = '0;
      endcase
    end
  end
endmodule

// File: rtl/scl_div.sv
module scl_div #(
  parameter int NUM_W = 25,
  parameter int DEN_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic             busy,
  output logic             q_valid,
  output logic [NUM_W-1:0] quo
);
  localparam int CNT_W = $clog2(NUM_W + 1);

  logic [NUM_W-1:0] acc_q, acc_n;
  logic [DEN_W:0]   rem_q, rem_n;
  logic [DEN_W-1:0] den_q, den_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             qv_q, qv_n;
  logic [DEN_W:0]   rem_sh;
  logic [DEN_W+1:0] diff;
  logic             ge;

  always_comb begin
    rem_sh = {rem_q[DEN_W-1:0], acc_q[NUM_W-1]};
    diff   = {1'b0, rem_sh} - {2'b00, den_q};
    ge     = ~diff[DEN_W+1];
    acc_n  = acc_q;
    rem_n  = rem_q;
    den_n  = den_q;
    cnt_n  = cnt_q;
    qv_n   = 1'b0;
    if (cnt_q != '0) begin
      rem_n = ge ? diff[DEN_W:0] : rem_sh;
      acc_n = {acc_q[NUM_W-2:0], ge};
      cnt_n = cnt_q - 1'b1;
      qv_n  = (cnt_q == CNT_W'(1));
    end else if (go) begin
      acc_n = num;
      rem_n = '0;
      den_n = den;
      cnt_n = CNT_W'(NUM_W);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      rem_q <= '0;
      den_q <= '0;
      cnt_q <= '0;
      qv_q  <= 1'b0;
    end else begin
      acc_q <= acc_n;
      rem_q <= rem_n;
      den_q <= den_n;
      cnt_q <= cnt_n;
      qv_q  <= qv_n;
    end
  end

  assign busy    = (cnt_q != '0);
  assign q_valid = qv_q;
  assign quo     = acc_q;
endmodule

// File: rtl/scale_step_calc.sv
module scale_step_calc
  import scl_pkg::*;
#(
  parameter int DIM_W = 12,
  parameter int FRAC  = 13,
  parameter int INC_W = 16,
  parameter int VPH_W = 16,
  parameter int HPH_W = 19
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [DIM_W-1:0] src_w,
  input  logic [DIM_W-1:0] src_h,
  input  logic [DIM_W-1:0] dst_w,
  input  logic [DIM_W-1:0] dst_h,
  input  logic [1:0]       src_fmt,
  input  logic [1:0]       dst_fmt,
  input  logic [2:0]       siting,
  output logic             done,
  output logic [INC_W-1:0] luma_v_inc,
  output logic [INC_W-1:0] luma_h_inc,
  output logic [INC_W-1:0] chroma_v_inc,
  output logic [INC_W-1:0] chroma_h_inc,
  output logic [VPH_W-1:0] chroma_v_phase,
  output logic [HPH_W-1:0] chroma_h_phase
);
  localparam int NUM_W = DIM_W + FRAC;
  localparam int N_OPS = 4;

  logic [DIM_W-1:0] c_src_w, c_src_h, c_dst_w;
  logic [VPH_W-1:0] c_vph;
  logic [HPH_W-1:0] c_hph;

  logic             busy_q, busy_n;
  logic             launch_q, launch_n;
  logic             done_q, done_n;
  div_op_e          op_q, op_n;
  logic [1:0]       fmt_q, fmt_n;
  logic [DIM_W-1:0] lsw_q, lsh_q, ldw_q, ldh_q, csw_q, csh_q, cdw_q;
  logic [DIM_W-1:0] lsw_n, lsh_n, ldw_n, ldh_n, csw_n, csh_n, cdw_n;
  logic [VPH_W-1:0] vph_q, vph_n;
  logic [HPH_W-1:0] hph_q, hph_n;
  logic [INC_W-1:0] inc_q [N_OPS];
  logic [INC_W-1:0] inc_n [N_OPS];

  logic [DIM_W-1:0] op_src, op_dst, div_den;
  logic [NUM_W-1:0] div_num, quo;
  logic             div_go, div_busy, q_valid;
  logic             accept;

  scl_prep #(.DIM_W(DIM_W), .FRAC(FRAC), .VPH_W(VPH_W), .HPH_W(HPH_W)) u_prep (
    .src_w(src_w), .src_h(src_h), .dst_w(dst_w),
    .src_fmt(src_fmt), .dst_fmt(dst_fmt), .siting(siting),
    .c_src_w(c_src_w), .c_src_h(c_src_h), .c_dst_w(c_dst_w),
    .c_vph(c_vph), .c_hph(c_hph)
  );

  always_comb begin
    case (op_q)
      OP_LUMA_V:   begin op_src = lsh_q; op_dst = ldh_q; end
      OP_CHROMA_V: begin op_src = csh_q; op_dst = ldh_q; end
      OP_LUMA_H:   begin op_src = lsw_q; op_dst = ldw_q; end
      default:     begin op_src = csw_q; op_dst = cdw_q; end
    endcase
    div_den = (op_dst == '0) ? DIM_W'(1) : op_dst;
    div_num = {op_src, {FRAC{1'b0}}} + NUM_W'(div_den >> 1);
    div_go  = launch_q;
  end

  scl_div #(.NUM_W(NUM_W), .DEN_W(DIM_W)) u_div (
    .clk(clk), .rst_n(rst_n), .go(div_go), .num(div_num), .den(div_den),
    .busy(div_busy), .q_valid(q_valid), .quo(quo)
  );

  assign accept = start && !busy_q;

  always_comb begin
    busy_n   = busy_q;
    launch_n = 1'b0;
    done_n   = 1'b0;
    op_n     = op_q;
    fmt_n    = fmt_q;
    lsw_n = lsw_q; lsh_n = lsh_q; ldw_n = ldw_q; ldh_n = ldh_q;
    csw_n = csw_q; csh_n = csh_q; cdw_n = cdw_q;
    vph_n = vph_q;
    hph_n = hph_q;
    for (int i = 0; i < N_OPS; i++) inc_n[i] = inc_q[i];
    if (accept) begin
      busy_n   = 1'b1;
      launch_n = 1'b1;
      op_n     = OP_LUMA_V;
      fmt_n    = src_fmt;
      lsw_n = src_w; lsh_n = src_h; ldw_n = dst_w; ldh_n = dst_h;
      csw_n = c_src_w; csh_n = c_src_h; cdw_n = c_dst_w;
      vph_n = c_vph;
      hph_n = c_hph;
    end else if (busy_q && q_valid) begin
      inc_n[op_q] = quo[INC_W-1:0];
      if (op_q == OP_CHROMA_H) begin
        busy_n = 1'b0;
        done_n = 1'b1;
      end else begin
        op_n     = div_op_e'(op_q + 2'd1);
        launch_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      launch_q <= 1'b0;
      done_q   <= 1'b0;
      op_q     <= OP_LUMA_V;
      fmt_q    <= FMT_444;
      lsw_q <= '0; lsh_q <= '0; ldw_q <= '0; ldh_q <= '0;
      csw_q <= '0; csh_q <= '0; cdw_q <= '0;
      vph_q <= '0;
      hph_q <= '0;
      for (int i = 0; i < N_OPS; i++) inc_q[i] <= '0;
    end else begin
      busy_q   <= busy_n;
      launch_q <= launch_n;
      done_q   <= done_n;
      op_q     <= op_n;
      fmt_q    <= fmt_n;
      lsw_q <= lsw_n; lsh_q <= lsh_n; ldw_q <= ldw_n; ldh_q <= ldh_n;
      csw_q <= csw_n; csh_q <= csh_n; cdw_q <= cdw_n;
      vph_q <= vph_n;
      hph_q <= hph_n;
      for (int i = 0; i < N_OPS; i++) inc_q[i] <= inc_n[i];
    end
  end

  assign done           = done_q;
  assign luma_v_inc     = inc_q[OP_LUMA_V];
  assign chroma_v_inc   = inc_q[OP_CHROMA_V];
  assign luma_h_inc     = inc_q[OP_LUMA_H];
  assign chroma_h_inc   = inc_q[OP_CHROMA_H];
  assign chroma_v_phase = vph_q;
  assign chroma_h_phase = hph_q;
endmodule

// File: rtl/scale_step_calc_chk.sv
module scale_step_calc_chk #(
  parameter int DIM_W = 12,
  parameter int FRAC  = 13,
  parameter int INC_W = 16,
  parameter int VPH_W = 16,
  parameter int HPH_W = 19
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             done,
  input logic             busy_q,
  input logic [1:0]       fmt_q,
  input logic [DIM_W-1:0] lsw_q,
  input logic [DIM_W-1:0] ldw_q,
  input logic             div_go,
  input logic [DIM_W-1:0] div_den,
  input logic [INC_W-1:0] luma_h_inc,
  input logic [VPH_W-1:0] chroma_v_phase,
  input logic [HPH_W-1:0] chroma_h_phase
);
  localparam logic [VPH_W-1:0] V_Q = VPH_W'(0) - VPH_W'(1 << (FRAC - 2));
  localparam logic [VPH_W-1:0] V_H = VPH_W'(0) - VPH_W'(1 << (FRAC - 1));
  localparam logic [HPH_W-1:0] H_Q = HPH_W'(0) - HPH_W'(1 << (FRAC - 2));

  p_done_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy_q);
  p_unity_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && lsw_q == ldw_q && lsw_q != '0) |-> luma_h_inc == INC_W'(1 << FRAC));
  p_den_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    div_go |-> div_den != '0);
  p_vphase_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (chroma_v_phase == '0 || chroma_v_phase == V_Q || chroma_v_phase == V_H));
  p_hphase_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (chroma_h_phase == '0 || chroma_h_phase == H_Q));
  p_zero_phase_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fmt_q != 2'd0) |-> (chroma_v_phase == '0 && chroma_h_phase == '0));
  p_busy_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start) |=> $stable(lsw_q) && $stable(ldw_q));
endmodule

bind scale_step_calc scale_step_calc_chk #(
  .DIM_W(DIM_W), .FRAC(FRAC), .INC_W(INC_W), .VPH_W(VPH_W), .HPH_W(HPH_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .done(done), .busy_q(busy_q),
  .fmt_q(fmt_q), .lsw_q(lsw_q), .ldw_q(ldw_q), .div_go(div_go),
  .div_den(div_den), .luma_h_inc(luma_h_inc),
  .chroma_v_phase(chroma_v_phase), .chroma_h_phase(chroma_h_phase)
);

// File: tb/scale_step_calc_bench.sv
`timescale 1ns/1ps
module scale_step_calc_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [11:0] src_w = '0, src_h = '0, dst_w = '0, dst_h = '0;
  logic [1:0]  src_fmt = '0, dst_fmt = '0;
  logic [2:0]  siting = '0;
  logic        done;
  logic [15:0] luma_v_inc, luma_h_inc, chroma_v_inc, chroma_h_inc, chroma_v_phase;
  logic [18:0] chroma_h_phase;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  scale_step_calc u_scale_step_calc (
    .clk(clk), .rst_n(rst_n), .start(start),
    .src_w(src_w), .src_h(src_h), .dst_w(dst_w), .dst_h(dst_h),
    .src_fmt(src_fmt), .dst_fmt(dst_fmt), .siting(siting),
    .done(done), .luma_v_inc(luma_v_inc), .luma_h_inc(luma_h_inc),
    .chroma_v_inc(chroma_v_inc), .chroma_h_inc(chroma_h_inc),
    .chroma_v_phase(chroma_v_phase), .chroma_h_phase(chroma_h_phase)
  );

  function automatic int step_of(int s, int d);
    int dd = (d == 0) ? 1 : d;
    return (((s << 13) + (dd >> 1)) / dd) & 32'hFFFF;
  endfunction

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic launch(int sw, int sh, int dw, int dh, int sf, int df, int st);
    @(negedge clk);
    src_w = 12'(sw); src_h = 12'(sh); dst_w = 12'(dw); dst_h = 12'(dh);
    src_fmt = 2'(sf); dst_fmt = 2'(df); siting = 3'(st);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output bit ok);
    int n = 0;
    ok = 1'b0;
    while (n < 400 && !ok) begin
      @(negedge clk);
      if (done) ok = 1'b1;
      n++;
    end
    if (!ok) chk("R1 watchdog", 0, 1);
  endtask

  task automatic run_check(int sw, int sh, int dw, int dh, int sf, int df, int st, bit zero_tag);
    int csw, csh, cdw, ev, eh;
    bit ok;
    launch(sw, sh, dw, dh, sf, df, st);
    wait_done(ok);
    if (!ok) return;
    csw = (sf == 0 || sf == 1) ? (sw >> 1) : sw;
    csh = (sf == 0) ? (sh >> 1) : sh;
    cdw = (df == 1) ? (dw >> 1) : dw;
    ev = 0; eh = 0;
    if (sf == 0) begin
      if (st == 0 || st == 1) ev = -2048;
      else if (st == 4 || st == 5) ev = -4096;
      if (st == 1 || st == 3 || st == 5) eh = -2048;
    end
    chk(zero_tag ? "R5 luma v" : "R2 luma v", int'(luma_v_inc), step_of(sh, dh));
    chk(zero_tag ? "R5 luma h" : "R2 luma h", int'(luma_h_inc), step_of(sw, dw));
    chk("R3 chroma v", int'(chroma_v_inc), step_of(csh, dh));
    chk("R4 chroma h", int'(chroma_h_inc), step_of(csw, cdw));
    chk(sf == 0 ? "R6 v phase" : "R8 v phase", int'(chroma_v_phase), ev & 32'hFFFF);
    chk(sf == 0 ? "R7 h phase" : "R8 h phase", int'(chroma_h_phase), eh & 32'h7FFFF);
    @(negedge clk);
    chk("R1 done pulse width", int'(done), 0);
    chk("R1 outputs held", int'(luma_h_inc), step_of(sw, dw));
  endtask

  initial begin
    int dims [6][4] = '{'{1920, 1080, 1280, 720}, '{640, 480, 1920, 1080},
                        '{4095, 4095, 1, 1}, '{100, 50, 100, 50},
                        '{7, 3, 0, 0}, '{1, 1, 4095, 4095}};
    bit ok;
    repeat (3) @(negedge clk);
    chk("R10 reset done", int'(done), 0);
    chk("R10 reset luma v", int'(luma_v_inc), 0);
    chk("R10 reset luma h", int'(luma_h_inc), 0);
    chk("R10 reset chroma v", int'(chroma_v_inc), 0);
    chk("R10 reset chroma h", int'(chroma_h_inc), 0);
    chk("R10 reset v phase", int'(chroma_v_phase), 0);
    chk("R10 reset h phase", int'(chroma_h_phase), 0);
    rst_n = 1'b1;

    for (int d = 0; d < 6; d++)
      for (int sf = 0; sf < 3; sf++)
        for (int df = 0; df < 3; df++)
          for (int st = 0; st < 8; st++)
            run_check(dims[d][0], dims[d][1], dims[d][2], dims[d][3], sf, df, st, d == 4);

    run_check(640, 480, 640, 480, 2, 2, 0, 1'b0);
    chk("R2 unity step", int'(luma_h_inc), 8192);

    // R9: a second start in mid-computation must not disturb the first
    launch(1920, 1080, 1280, 720, 0, 2, 4);
    repeat (10) @(negedge clk);
    start = 1'b1; src_w = 12'd100; dst_w = 12'd7; src_fmt = 2'd2; siting = 3'd0;
    @(negedge clk);
    start = 1'b0;
    wait_done(ok);
    chk("R9 ignored start luma h", int'(luma_h_inc), step_of(1920, 1280));
    chk("R9 ignored start v phase", int'(chroma_v_phase), (-4096) & 32'hFFFF);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL R1 global watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule